// File: doc/BRIEF.md
# Retired Instruction and Read-Beat Trace Buffer

This block keeps a short history of what a processor core has recently done. Each time the core retires an instruction, the block records the program counter along with a small tag. The tag holds the core's control-state code and its code-segment selector. Separately, it records the address and raw data of every memory read beat the core's bus master accepts. Both histories live in circular buffers of `DEPTH` entries, written so that block RAM can be inferred. Once the buffer is full, the newest entry overwrites the oldest.

Software reaches the buffers through a small word-addressed register port. It writes a relative "N-back" index, where 0 is the newest entry, and then reads the selected record. The buffers are synchronous RAMs, so a selection takes one extra cycle to reach the output. After changing the index, software issues one throw-away read and then reads the real value. Two further registers report how many valid entries each buffer holds. A write-one pulse empties both buffers. A constant identification word lets software detect that the block is present.

Top module: `pc_trace_ring`

## Requirements
- R1: A read of register address 0 returns the identification word 0xDB010020: magic 0xDB in bits [31:24], version 1 in [23:16], and the depth (32) in [15:0].
- R2: After reset, register address 1 (index) reads 0, and register address 6 (beat count) reads 0.
- R3: On a cycle with `ret_valid` high, the retire buffer stores `ret_pc` and a tag. Register address 2 returns the PC of the selected entry. Register address 3 returns the tag as {`ret_state`[5:0] in bits [21:16], `ret_sel`[15:0] in bits [15:0]}, with the upper bits zero.
- R4: Writing register address 1 sets the N-back index from `reg_wdata`[4:0]. Reading register address 1 returns that index in bits [4:0] and the retire entry count in bits [13:8]. The count rises by one per retire and holds at 32.
- R5: The RAM read has one cycle of latency. A data-register read in the cycle right after an index write returns the record chosen by the previous index. A read one cycle later returns the record for the new index.
- R6: On a cycle with `beat_valid` high, the beat buffer stores `beat_addr` and `beat_data`. These are read through register addresses 4 (address) and 5 (data), using the same N-back index.
- R7: Register address 6 returns the beat entry count in bits [5:0]. It rises by one per beat, holds at 32, and is independent of the retire count.
- R8: Writing register address 7 with bit 0 set empties both buffers: both counts read 0, and the next capture becomes entry 0. Writing address 7 with bit 0 clear changes nothing.
- R9: If a clear and a capture fall in the same cycle, the clear wins and the count reads 0 afterwards.
- R10: After more than 32 captures, index k returns the k-th most recent capture for every k from 0 to 31.
- R11: `reg_rdata` is registered. It changes only in the cycle after a `reg_rd` pulse and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ret_valid | input | 1 | Instruction retire strobe |
| ret_pc | input | 32 | Retired program counter |
| ret_sel | input | 16 | Code-segment selector at retire |
| ret_state | input | 6 | Core control-state code at retire |
| beat_valid | input | 1 | Accepted read-beat strobe |
| beat_addr | input | 32 | Address of the read beat |
| beat_data | input | 32 | Raw data of the read beat |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data, valid the cycle after `reg_rd` |

## Verification
- **Wrong write pointer or offset:** every N-back read returns a neighbour's record. A random history makes this visible at the first data read after the fault.
- **Wrong count:** the saturation and clear tests expose it within one register read. A count that fails to saturate shows at capture 33.
- **Lost clear priority:** a simultaneous clear and capture leaves a count of 1 instead of 0, seen on the very next index read.
- **Missing or doubled read latency:** the throw-away read returns the new record, or the second read returns the old one, in the two cycles after an index write.

// File: rtl/trace_ring_pkg.sv
package trace_ring_pkg;

  typedef enum logic [2:0] {
    RA_CAP    = 3'd0,
    RA_INDEX  = 3'd1,
    RA_PC     = 3'd2,
    RA_TAG    = 3'd3,
    RA_BADDR  = 3'd4,
    RA_BDATA  = 3'd5,
    RA_BCOUNT = 3'd6,
    RA_CTRL   = 3'd7
  } reg_sel_e;

  localparam logic [7:0] ID_MAGIC   = 8'hDB;
  localparam logic [7:0] ID_VERSION = 8'h01;

  typedef struct packed {
    logic [5:0]  state;
    logic [15:0] sel;
  } ret_tag_t;

endpackage

// File: rtl/trace_ring_store.sv
module trace_ring_store #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 32
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              clr,
  input  logic                              wr_en,
  input  logic [WIDTH-1:0]                  wr_data,
  input  logic [$clog2(DEPTH)-1:0]          back,
  output logic [WIDTH-1:0]                  rd_data,
  output logic [$clog2(DEPTH+1)-1:0]        count
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [IDX_W-1:0] wptr;
  logic [IDX_W-1:0] raddr;
  logic             take;

  assign take  = wr_en && !clr;
  // newest entry sits one slot behind the write pointer; power-of-two wrap
  assign raddr = wptr - IDX_W'(1) - back;

  always_ff @(posedge clk) begin
    if (take) mem[wptr] <= wr_data;
    rd_data <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr  <= '0;
      count <= '0;
    end else if (wr_en) begin
      wptr <= wptr + IDX_W'(1);
      if (count != FULL) count <= count + CNT_W'(1);
    end
  end

  p_cnt_max_r4: assert property (@(posedge clk) disable iff (rst)
    count <= FULL);
  p_cnt_step_r4: assert property (@(posedge clk) disable iff (rst)
    (take && count != FULL) |=> count == $past(count) + CNT_W'(1));
  p_cnt_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (take && count == FULL) |=> count == FULL);
  p_clr_empty_r8: assert property (@(posedge clk) disable iff (rst)
    clr |=> count == '0);
  p_clr_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (clr && wr_en) |=> (count == '0 && wptr == '0));
  p_wptr_step_r10: assert property (@(posedge clk) disable iff (rst)
    take |=> wptr == $past(wptr) + IDX_W'(1));
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !clr) |=> $stable(wptr) && $stable(count));
endmodule

// File: rtl/trace_ring_regs.sv
module trace_ring_regs
  import trace_ring_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int PC_W  = 32,
  parameter int TAG_W = 22,
  parameter int BA_W  = 32,
  parameter int BD_W  = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       reg_wr,
  input  logic                       reg_rd,
  input  logic [2:0]                 reg_addr,
  input  logic [31:0]                reg_wdata,
  output logic [31:0]                reg_rdata,
  output logic                       clr,
  output logic [$clog2(DEPTH)-1:0]   back,
  input  logic [PC_W-1:0]            pc_q,
  input  logic [TAG_W-1:0]           tag_q,
  input  logic [BA_W-1:0]            baddr_q,
  input  logic [BD_W-1:0]            bdata_q,
  input  logic [$clog2(DEPTH+1)-1:0] ret_cnt,
  input  logic [$clog2(DEPTH+1)-1:0] beat_cnt
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [31:0] ID_WORD = {ID_MAGIC, ID_VERSION, 16'(DEPTH)};

  logic [31:0] rd_mux;
  logic [31:0] idx_word;

  assign clr = reg_wr && (reg_addr == RA_CTRL) && reg_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) back <= '0;
    else if (reg_wr && reg_addr == RA_INDEX) back <= reg_wdata[IDX_W-1:0];
  end

  always_comb begin
    idx_word = '0;
    idx_word[IDX_W-1:0] = back;
    idx_word[8 +: CNT_W] = ret_cnt;
  end

  always_comb begin
    unique case (reg_sel_e'(reg_addr))
      RA_CAP:    rd_mux = ID_WORD;
      RA_INDEX:  rd_mux = idx_word;
      RA_PC:     rd_mux = 32'(pc_q);
      RA_TAG:    rd_mux = 32'(tag_q);
      RA_BADDR:  rd_mux = 32'(baddr_q);
      RA_BDATA:  rd_mux = 32'(bdata_q);
      RA_BCOUNT: rd_mux = 32'(beat_cnt);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  p_id_word_r1: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == RA_CAP) |=> reg_rdata == ID_WORD);
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata));
  p_index_set_r4: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == RA_INDEX) |=> back == $past(reg_wdata[IDX_W-1:0]));
endmodule

// File: rtl/pc_trace_ring.sv
module pc_trace_ring
  import trace_ring_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int PC_W  = 32,
  parameter int BA_W  = 32,
  parameter int BD_W  = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ret_valid,
  input  logic [PC_W-1:0] ret_pc,
  input  logic [15:0]     ret_sel,
  input  logic [5:0]      ret_state,
  input  logic            beat_valid,
  input  logic [BA_W-1:0] beat_addr,
  input  logic [BD_W-1:0] beat_data,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [2:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam int TAG_W = $bits(ret_tag_t);
  localparam int RW    = PC_W + TAG_W;
  localparam int BW    = BA_W + BD_W;

  logic             clr;
  logic [IDX_W-1:0] back;
  logic [CNT_W-1:0] ret_cnt, beat_cnt;
  logic [RW-1:0]    ret_word, ret_q;
  logic [BW-1:0]    beat_word, beat_q;
  ret_tag_t         tag_in;

  assign tag_in    = '{state: ret_state, sel: ret_sel};
  assign ret_word  = {ret_pc, tag_in};
  assign beat_word = {beat_addr, beat_data};

  trace_ring_store #(.WIDTH(RW), .DEPTH(DEPTH)) u_ret_ring (
    .clk, .rst, .clr, .wr_en(ret_valid), .wr_data(ret_word),
    .back, .rd_data(ret_q), .count(ret_cnt)
  );

  trace_ring_store #(.WIDTH(BW), .DEPTH(DEPTH)) u_beat_ring (
    .clk, .rst, .clr, .wr_en(beat_valid), .wr_data(beat_word),
    .back, .rd_data(beat_q), .count(beat_cnt)
  );

  trace_ring_regs #(
    .DEPTH(DEPTH), .PC_W(PC_W), .TAG_W(TAG_W), .BA_W(BA_W), .BD_W(BD_W)
  ) u_regs (
    .clk, .rst, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
    .clr, .back,
    .pc_q(ret_q[RW-1 -: PC_W]), .tag_q(ret_q[TAG_W-1:0]),
    .baddr_q(beat_q[BW-1 -: BA_W]), .bdata_q(beat_q[BD_W-1:0]),
    .ret_cnt, .beat_cnt
  );
endmodule

// File: tb/tb_pc_trace_ring.sv
module tb_pc_trace_ring;
  logic        clk = 0;
  logic        rst = 1;
  logic        ret_valid = 0, beat_valid = 0, reg_wr = 0, reg_rd = 0;
  logic [31:0] ret_pc = 0, beat_addr = 0, beat_data = 0, reg_wdata = 0;
  logic [15:0] ret_sel = 0;
  logic [5:0]  ret_state = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_rdata;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_pc [4096];
  logic [31:0] m_tag[4096];
  logic [31:0] m_ba [4096];
  logic [31:0] m_bd [4096];
  int n_ret = 0, n_beat = 0;

  always #2.5 clk = ~clk;

  pc_trace_ring dut (.*);

  function automatic int sat(input int n);
    return (n > 32) ? 32 : n;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic drive(input bit rv, input bit bv, input bit wr, input bit rd,
                       input logic [2:0] a, input logic [31:0] wd);
    @(negedge clk);
    ret_valid = rv; beat_valid = bv; reg_wr = wr; reg_rd = rd;
    reg_addr = a; reg_wdata = wd;
    if (rv) begin
      ret_pc = $urandom; ret_sel = 16'($urandom); ret_state = 6'($urandom);
      m_pc[n_ret] = ret_pc; m_tag[n_ret] = {10'd0, ret_state, ret_sel};
    end
    if (bv) begin
      beat_addr = $urandom; beat_data = $urandom;
      m_ba[n_beat] = beat_addr; m_bd[n_beat] = beat_data;
    end
    if (wr && a == 3'd7 && wd[0]) begin n_ret = 0; n_beat = 0; end
    else begin
      if (rv) n_ret++;
      if (bv) n_beat++;
    end
  endtask

  task automatic idle(); drive(0, 0, 0, 0, 0, 0); endtask
  task automatic wreg(input logic [2:0] a, input logic [31:0] d); drive(0, 0, 1, 0, a, d); endtask
  task automatic rreg(input logic [2:0] a, output logic [31:0] v);
    drive(0, 0, 0, 1, a, 0);
    @(posedge clk); #1 v = reg_rdata;
  endtask

  task automatic check_entry(input int k);
    logic [31:0] v;
    wreg(1, k);
    rreg(2, v);
    rreg(2, v);
    if (k < sat(n_ret)) begin
      check("R3 pc", v, m_pc[n_ret-1-k]);
      rreg(3, v); check("R3 tag", v, m_tag[n_ret-1-k]);
    end
    if (k < sat(n_beat)) begin
      rreg(4, v); check("R6 beat addr", v, m_ba[n_beat-1-k]);
      rreg(5, v); check("R6 beat data", v, m_bd[n_beat-1-k]);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, stale;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    idle();
    rreg(0, v); check("R1 id word", v, 32'hDB010020);
    rreg(1, v); check("R2 index after reset", v, 0);
    rreg(6, v); check("R2 beat count after reset", v, 0);

    // R11: output holds without a read
    idle(); idle(); @(posedge clk); #1 check("R11 hold", reg_rdata, 0);

    repeat (5) drive(1, 0, 0, 0, 0, 0);
    repeat (3) drive(0, 1, 0, 0, 0, 0);
    for (int k = 0; k < 5; k++) check_entry(k);
    wreg(1, 3); rreg(1, v); check("R4 index and count", v, {18'd0, 6'd5, 3'd0, 5'd3});
    rreg(6, v); check("R7 beat count", v, 3);

    // R5 latency: ram settled on entry 0, then switch to entry 2
    wreg(1, 0); rreg(2, v); rreg(2, v);
    wreg(1, 2); rreg(2, stale); check("R5 stale read", stale, m_pc[n_ret-1]);
    rreg(2, v); check("R5 fresh read", v, m_pc[n_ret-3]);

    // R10 wrap and saturation
    repeat (40) drive(1, 1, 0, 0, 0, 0);
    rreg(1, v); check("R4 count saturates", v[13:8], 32);
    rreg(6, v); check("R7 beat count saturates", v, 32);
    for (int k = 0; k < 32; k++) check_entry(k);

    // R8 clear; a zero write does nothing first
    wreg(7, 0); rreg(1, v); check("R8 no-op ctrl write", v[13:8], 32);
    wreg(7, 1); rreg(1, v); check("R8 cleared count", v[13:8], 0);
    rreg(6, v); check("R8 cleared beat count", v, 0);
    drive(1, 1, 0, 0, 0, 0); check_entry(0);

    // R9 clear with capture same cycle
    drive(1, 1, 1, 0, 3'd7, 1);
    rreg(1, v); check("R9 clear wins", v[13:8], 0);
    rreg(6, v); check("R9 clear wins beat", v, 0);
    drive(1, 0, 0, 0, 0, 0); check_entry(0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 5) drive(op[0], op[1], 0, 0, 0, 0);
      else if (op < 8) check_entry($urandom_range(0, 31));
      else if (op == 8) begin
        rreg(1, v); check("R4 random count", v[13:8], sat(n_ret));
        rreg(6, v); check("R7 random beat count", v, sat(n_beat));
      end else if ($urandom_range(0, 7) == 0) wreg(7, 1);
    end
    idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule